// File: doc/BRIEF.md
# Transmit Pin Mux with Output-Enable Indication

This block sits at the transmit edge of a time-slot switch and decides, for each of its transmit pins, what the pin carries and whether it is driven. In normal switch mode every pin carries the serial bit of its own output stream, and is driven only when that stream is active in the current channel slot. A stream is active when the connection-memory entry for the current channel does not request high impedance, and the global output drivers are turned on either by the external drive-enable pin or by a configuration bit.

Any pin can instead be used as an indicator that reports whether a stream is being driven, so that a companion switch programmed identically can be monitored or used to steer external buffers. The upper half of the pins can report on the lower half of the streams, or every pin can report on its own stream. The indicator polarity is selectable, and indicator pins are always driven. The drive state of each stream is captured once per channel, at a channel-boundary strobe, from the mode field of that channel's connection-memory entry; the indicator follows it in the same slot.

Top module: `txind_pin_mux`

## Requirements
- R1: After reset all four configuration bits are 0, every stream's drive state is off, every `tx_oe` bit is 0 and every `tx_pin` bit is 0.
- R2: In normal mode (`all_ind`=0 and, for the upper half, `half_ind`=0), a driven pin i shows the value `ser_data[i]` sampled at the previous rising clock edge.
- R3: A stream is active only when its drive state is on and at least one of `drv_en` and `out_on` is 1; a data pin's `tx_oe` equals its stream's activity, so with `drv_en`=0 and `out_on`=0 no data pin is driven.
- R4: At a clock edge where `ch_strobe` is 1, stream i's drive state becomes off when `cm_mode[2i+1:2i]` is 2'b11 and on for 2'b00, 2'b01 or 2'b10.
- R5: At a clock edge where `ch_strobe` is 0, `cm_mode` has no effect: every stream keeps its drive state.
- R6: With `half_ind`=1 and `all_ind`=0, pin N/2+k (k from 0 to N/2-1) is an indicator for stream k; pins 0 to N/2-1 stay data pins.
- R7: With `ind_pol`=1 an indicator pin shows 1 for an active stream and 0 for an inactive one; with `ind_pol`=0 the meaning is inverted.
- R8: With `all_ind`=1 every pin i is an indicator for stream i, whatever the value of `half_ind`.
- R9: An indicator pin always has `tx_oe`=1, also while `drv_en` and `out_on` are both 0 (it then reports an inactive stream).
- R10: At a clock edge where `cfg_we` is 1 the configuration is loaded from `cfg_wdata` with bit 3 = `all_ind`, bit 2 = `half_ind`, bit 1 = `ind_pol`, bit 0 = `out_on`; otherwise it is held.
- R11: Any pin whose `tx_oe` is 0 shows 0 on `tx_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| cfg_we | input | 1 | Load strobe for the configuration bits |
| cfg_wdata | input | 4 | Configuration value: {all_ind, half_ind, ind_pol, out_on} |
| drv_en | input | 1 | External output-drive enable |
| ch_strobe | input | 1 | Channel boundary: capture the per-stream drive state |
| cm_mode | input | 2*N | Connection-memory mode field of the current channel, two bits per stream |
| ser_data | input | N | Serial output bit of each stream |
| tx_pin | output | N | Transmit pin values |
| tx_oe | output | N | Transmit pin tristate enables (1 = driven) |

## Verification
The embedded properties check on every cycle that configuration and drive state only move on their strobes, that an indicator pin is never tristated, that an undriven pin reads 0, and that with both drive enables low and indicators off nothing is driven. What those properties cannot show is that the right stream reaches the right pin: the mapping of upper pins onto lower streams, the priority of all-pin indication over half-pin indication, the polarity inversion and the decoding of the high-impedance mode code are shown only by the bench's scenarios, which compare every pin against a model built from the requirements.

// File: rtl/txind_pkg.sv
package txind_pkg;

  // Connection-memory mode field values
  typedef enum logic [1:0] {
    MODE_VAR_DLY   = 2'b00,
    MODE_CONST_DLY = 2'b01,
    MODE_PROC      = 2'b10,
    MODE_HIZ       = 2'b11
  } cm_mode_e;

  // Configuration bits, packed in write order {3,2,1,0}
  typedef struct packed {
    logic all_ind;   // every pin reports its own stream
    logic half_ind;  // upper pins report lower streams
    logic ind_pol;   // 1: indicator high means active
    logic out_on;    // data drivers on regardless of drv_en
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic logic mode_forces_hiz(input logic [1:0] mode);
    return mode == MODE_HIZ;
  endfunction

endpackage

// File: rtl/txind_cfg_reg.sv
module txind_cfg_reg
  import txind_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output cfg_t             cfg_q
);

  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = cfg_t'(wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

  // R10
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(wr_data)));

endmodule

// File: rtl/txind_hiz_stub.sv
module txind_hiz_stub
  import txind_pkg::*;
#(
  parameter int N_STREAMS = 32
) (
  input  logic [2*N_STREAMS-1:0] cm_mode,
  output logic [N_STREAMS-1:0]   hiz_req
);

  // Stand-in for the connection memory read path: one decoder per stream
  for (genvar s = 0; s < N_STREAMS; s++) begin : g_dec
    always_comb begin
      hiz_req[s] = mode_forces_hiz(cm_mode[2*s +: 2]);
    end
  end

endmodule

// File: rtl/txind_drive_state.sv
module txind_drive_state #(
  parameter int N_STREAMS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ch_strobe,
  input  logic [N_STREAMS-1:0] hiz_req,
  input  logic [N_STREAMS-1:0] ser_data,
  output logic [N_STREAMS-1:0] drive_q,
  output logic [N_STREAMS-1:0] data_q
);

  logic [N_STREAMS-1:0] drive_d;
  logic [N_STREAMS-1:0] data_d;

  always_comb begin
    drive_d = drive_q;
    if (ch_strobe) begin
      drive_d = ~hiz_req;
    end
    data_d = ser_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      data_q  <= '0;
    end else begin
      drive_q <= drive_d;
      data_q  <= data_d;
    end
  end

  // R5
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_strobe |=> $stable(drive_q));

  // R4
  drive_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_strobe |=> (drive_q == ~$past(hiz_req)));

endmodule

// File: rtl/txind_pin_select.sv
module txind_pin_select
  import txind_pkg::*;
#(
  parameter int N_STREAMS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cfg_t                 cfg,
  input  logic                 drv_en,
  input  logic [N_STREAMS-1:0] drive_q,
  input  logic [N_STREAMS-1:0] data_q,
  output logic [N_STREAMS-1:0] tx_pin,
  output logic [N_STREAMS-1:0] tx_oe
);

  localparam int HALF = N_STREAMS / 2;

  logic                 drivers_on;
  logic [N_STREAMS-1:0] active;
  logic [N_STREAMS-1:0] ind;

  always_comb begin
    drivers_on = drv_en | cfg.out_on;
    active     = drive_q & {N_STREAMS{drivers_on}};
    ind        = cfg.ind_pol ? active : ~active;
  end

  for (genvar p = 0; p < N_STREAMS; p++) begin : g_pin
    if (p >= HALF) begin : g_upper
      always_comb begin
        if (cfg.all_ind) begin
          tx_pin[p] = ind[p];
          tx_oe[p]  = 1'b1;
        end else if (cfg.half_ind) begin
          tx_pin[p] = ind[p-HALF];
          tx_oe[p]  = 1'b1;
        end else begin
          tx_pin[p] = active[p] & data_q[p];
          tx_oe[p]  = active[p];
        end
      end

      // R9
      upper_ind_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.all_ind || cfg.half_ind) |-> tx_oe[p]);
    end else begin : g_lower
      always_comb begin
        if (cfg.all_ind) begin
          tx_pin[p] = ind[p];
          tx_oe[p]  = 1'b1;
        end else begin
          tx_pin[p] = active[p] & data_q[p];
          tx_oe[p]  = active[p];
        end
      end

      // R9
      lower_ind_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.all_ind |-> tx_oe[p]);
    end

    // R11
    undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe[p] |-> !tx_pin[p]);
  end

endmodule

// File: rtl/txind_pin_mux.sv
module txind_pin_mux
  import txind_pkg::*;
#(
  parameter int N_STREAMS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_W-1:0]       cfg_wdata,
  input  logic                   drv_en,
  input  logic                   ch_strobe,
  input  logic [2*N_STREAMS-1:0] cm_mode,
  input  logic [N_STREAMS-1:0]   ser_data,
  output logic [N_STREAMS-1:0]   tx_pin,
  output logic [N_STREAMS-1:0]   tx_oe
);

  cfg_t                 cfg_q;
  logic [N_STREAMS-1:0] hiz_req;
  logic [N_STREAMS-1:0] drive_q;
  logic [N_STREAMS-1:0] data_q;

  txind_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg_q   (cfg_q)
  );

  txind_hiz_stub #(.N_STREAMS(N_STREAMS)) u_hiz (
    .cm_mode (cm_mode),
    .hiz_req (hiz_req)
  );

  txind_drive_state #(.N_STREAMS(N_STREAMS)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_strobe (ch_strobe),
    .hiz_req   (hiz_req),
    .ser_data  (ser_data),
    .drive_q   (drive_q),
    .data_q    (data_q)
  );

  txind_pin_select #(.N_STREAMS(N_STREAMS)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg_q),
    .drv_en  (drv_en),
    .drive_q (drive_q),
    .data_q  (data_q),
    .tx_pin  (tx_pin),
    .tx_oe   (tx_oe)
  );

  // R3
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en && !cfg_q.out_on && !cfg_q.all_ind && !cfg_q.half_ind) |-> (tx_oe == '0));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (tx_oe == '0 && tx_pin == '0));

endmodule

// File: tb/sim_txind_pin_mux.sv
module sim_txind_pin_mux;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int H = N / 2;

  logic           clk;
  logic           rst_n;
  logic           cfg_we;
  logic [3:0]     cfg_wdata;
  logic           drv_en;
  logic           ch_strobe;
  logic [2*N-1:0] cm_mode;
  logic [N-1:0]   ser_data;
  logic [N-1:0]   tx_pin;
  logic [N-1:0]   tx_oe;

  int checks;
  int errors;
  bit done;

  // bench model of the state the requirements define
  logic [3:0]   m_cfg;   // {all_ind, half_ind, ind_pol, out_on}
  logic         m_drv_en;
  logic [N-1:0] m_drive;
  logic [N-1:0] m_data;

  logic [2*N-1:0] exp_q[$];
  string          tag_q[$];

  txind_pin_mux #(.N_STREAMS(N)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .drv_en    (drv_en),
    .ch_strobe (ch_strobe),
    .cm_mode   (cm_mode),
    .ser_data  (ser_data),
    .tx_pin    (tx_pin),
    .tx_oe     (tx_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2*N-1:0] model_out();
    logic [N-1:0] act, ind, pin, oe;
    act = m_drive & {N{m_drv_en | m_cfg[0]}};
    ind = m_cfg[1] ? act : ~act;
    for (int i = 0; i < N; i++) begin
      if (m_cfg[3]) begin
        pin[i] = ind[i]; oe[i] = 1'b1;
      end else if (m_cfg[2] && i >= H) begin
        pin[i] = ind[i-H]; oe[i] = 1'b1;
      end else begin
        oe[i] = act[i]; pin[i] = act[i] & m_data[i];
      end
    end
    return {oe, pin};
  endfunction

  task automatic check(input string tag, input logic [N-1:0] got_pin, input logic [N-1:0] got_oe,
                       input logic [N-1:0] exp_pin, input logic [N-1:0] exp_oe);
    checks++;
    if (got_pin !== exp_pin || got_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: pin=%h oe=%h expected pin=%h oe=%h", tag, got_pin, got_oe, exp_pin, exp_oe);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result after the next edge
  task automatic step(input logic we, input logic [3:0] wd, input logic de, input logic stb,
                      input logic [2*N-1:0] modes, input logic [N-1:0] data, input string tag);
    @(negedge clk);
    cfg_we    = we;
    cfg_wdata = wd;
    drv_en    = de;
    ch_strobe = stb;
    cm_mode   = modes;
    ser_data  = data;
    if (we) m_cfg = wd;
    m_drv_en = de;
    if (stb) begin
      for (int s = 0; s < N; s++) m_drive[s] = (modes[2*s +: 2] != 2'b11);
    end
    m_data = data;
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2*N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, tx_pin, tx_oe, e[N-1:0], e[2*N-1:N]);
      end
    end
  end

  function automatic logic [2*N-1:0] mixed_modes();
    logic [2*N-1:0] m;
    for (int s = 0; s < N; s++) m[2*s +: 2] = 2'(s % 3);
    m[2*3 +: 2]  = 2'b11;
    m[2*20 +: 2] = 2'b11;
    return m;
  endfunction

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = '0; drv_en = 0; ch_strobe = 0;
    cm_mode = '0; ser_data = '0;
    m_cfg = '0; m_drv_en = 0; m_drive = '0; m_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", tx_pin, tx_oe, '0, '0);

    // R10 R2: enable drivers by config, all streams driven
    step(1, 4'b0001, 0, 1, '0, 32'hA5A5_0F0F, "R10 R2 data after config load");
    step(0, 4'b1111, 0, 0, '0, 32'h1234_5678, "R2 R10 data, config held");
    // R5: modes requesting hiz without strobe are ignored
    step(0, 4'b0000, 0, 0, {2*N{1'b1}}, 32'hFFFF_FFFF, "R5 no strobe, modes ignored");
    // R4: strobe with hiz on streams 3 and 20
    step(0, 4'b0000, 0, 1, mixed_modes(), 32'hFFFF_FFFF, "R4 hiz on streams 3 and 20");
    step(0, 4'b0000, 0, 0, '0, 32'hC3C3_3C3C, "R5 R11 state held, hiz pins low");
    // R3: external enable alone drives
    step(1, 4'b0000, 1, 0, '0, 32'h0F0F_F0F0, "R3 drv_en alone drives");
    step(0, 4'b0000, 0, 0, '0, 32'hFFFF_FFFF, "R3 both enables off");
    // R9 R7 indicators with drivers off
    step(1, 4'b0110, 0, 0, '0, 32'hFFFF_FFFF, "R9 R7 upper indicators, drivers off, pol 1");
    step(1, 4'b0100, 0, 0, '0, 32'hFFFF_FFFF, "R9 R7 upper indicators, drivers off, pol 0");
    // R6 R7 upper indicators with drivers on
    step(1, 4'b0111, 0, 0, '0, 32'h5555_AAAA, "R6 upper pins show lower streams, pol 1");
    step(1, 4'b0101, 0, 0, '0, 32'h5555_AAAA, "R6 R7 upper pins inverted, pol 0");
    // R8 all-pin indication and its priority
    step(1, 4'b1011, 0, 0, '0, 32'h0000_0000, "R8 all pins indicate own stream");
    step(1, 4'b1111, 0, 0, '0, 32'h0000_0000, "R8 all-pin wins over half-pin");
    step(1, 4'b1000, 0, 0, '0, 32'h0000_0000, "R8 R9 all indicators, drivers off, pol 0");
    // R4 every mode 11, then each non-hiz mode
    step(1, 4'b0001, 0, 1, {2*N{1'b1}}, 32'hFFFF_FFFF, "R4 all streams hiz");
    step(0, 4'b0000, 0, 1, {N{2'b01}}, 32'h8001_7FFE, "R4 mode 01 drives");
    step(0, 4'b0000, 0, 1, {N{2'b10}}, 32'h6666_9999, "R4 mode 10 drives");
    step(0, 4'b0000, 1, 1, mixed_modes(), 32'hDEAD_BEEF, "R4 R2 mixed modes with both enables");
    step(1, 4'b0111, 1, 1, {N{2'b00}}, 32'h0000_FFFF, "R6 R4 strobe and indicator in same slot");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule